// File: doc/BRIEF.md
# Two-Bank Shared Memory with Write-Watch Interrupts

This block is a small shared memory split into two equal banks. Two bus ports reach it: a host port and a guest port. Each port can reach either bank. When the two ports use different banks in the same cycle, both accesses complete. When they use the same bank, the host port always wins, and the guest port waits with its ready signal held low.

Each bank has one write watcher. Software loads it through a small register port with the index of one aligned 32-bit word and a valid flag. Any write to that word, from either port, with at least one byte lane enabled, sets a sticky status flag for the bank. Each status flag has its own enable, and a single interrupt line goes to the host. Software acknowledges a flag by writing zero to its status bit.

Top module: `shared_sram_mon`

## Requirements
- R1: After a synchronous active-low reset, every configuration register reads 0, `irq` is low, and neither read-valid output is asserted.
- R2: Address bit 12 selects the bank and bits 11:2 select the word. A granted read returns its data with `*_rvalid` high one cycle after the cycle in which `*_ready` was high.
- R3: A write changes only the byte lanes whose `*_be` bit is set. Bit k of `*_be` covers data bits 8k+7 down to 8k.
- R4: When the host and guest request different banks in the same cycle, both `h_ready` and `g_ready` are high in that cycle.
- R5: When both ports request the same bank, `h_ready` is high and `g_ready` stays low for every cycle in which the host keeps requesting that bank. The stalled guest access completes in the first cycle in which the host does not request that bank.
- R6: Watcher registers sit at offset 0x0 (bank 0) and 0x4 (bank 1). Bit 0 is the valid flag and bits 11:2 are the watched word index. Every other bit reads as 0.
- R7: While a watcher is valid, a write with a nonzero `*_be` to the watched word of its bank, from either port, sets that bank's status bit. The status register is at offset 0x8, with bit 0 for bank 0 and bit 1 for bank 1. The bit reads set in the cycle after the write. Reads, writes to other words, writes to the other bank, writes with `*_be` = 0, and writes while the watcher is invalid leave the bit unchanged.
- R8: Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. If a watch hit and a clear of the same bit happen in the same cycle, the bit stays set.
- R9: Enables are at offset 0xc, with bit 0 for bank 0 and bit 1 for bank 1. `irq` is the OR of each status bit ANDed with its enable. Enabling a bit whose status is already set raises `irq` in the cycle after the enable write.
- R10: `cfg_rdata` shows the register selected by `cfg_addr` in the same cycle, with no read strobe. Register writes take effect at the clock edge on which `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 13 | Host byte address; bit 12 selects the bank |
| h_wdata | input | 32 | Host write data |
| h_be | input | 4 | Host byte-lane enables |
| h_ready | output | 1 | Host access accepted this cycle |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | 32 | Host read data |
| g_req | input | 1 | Guest access request |
| g_we | input | 1 | Guest write (1) or read (0) |
| g_addr | input | 13 | Guest byte address; bit 12 selects the bank |
| g_wdata | input | 32 | Guest write data |
| g_be | input | 4 | Guest byte-lane enables |
| g_ready | output | 1 | Guest access accepted this cycle |
| g_rvalid | output | 1 | Guest read data valid |
| g_rdata | output | 32 | Guest read data |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 4 | Configuration register byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational |
| irq | output | 1 | Interrupt to the host |

## Verification
The results arrive with three different delays:
- Grant decisions (`*_ready`) are combinational, so the bench reads them 1 ns after it drives a request, before the next rising edge.
- Read data, status bits and `irq` are registered once, so the bench samples them at the falling edge after the rising edge that performed the access or register write.
- Configuration readback is combinational from `cfg_addr`, so the bench reads it shortly after it drives the offset.

Stall cases hold the host request for several cycles and check `g_ready` in each of them. The completed guest write is then read back through the host port.

// File: rtl/sram_mon_pkg.sv
// Shared constants for the two-bank watched memory.
// Assumes exactly two banks, selected by the top address bit.
package sram_mon_pkg;
    localparam int NUM_BANKS = 2;
    localparam int CFG_AW    = 4;
    localparam logic [CFG_AW-1:0] OFS_MON0 = 4'h0;
    localparam logic [CFG_AW-1:0] OFS_STAT = 4'h8;
    localparam logic [CFG_AW-1:0] OFS_EN   = 4'hC;
endpackage

// File: rtl/sram_bank_arb.sv
// Fixed-priority grant for one bank: the host request always wins and
// the guest is granted only when the host is not using this bank.
// Assumes hits are already qualified by request and bank select.
module sram_bank_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic h_hit,
    input  logic g_hit,
    output logic grant_h,
    output logic grant_g
);
    // Grant decision, purely combinational.
    always_comb begin
        grant_h = h_hit;
        grant_g = g_hit && !h_hit;
    end

    // R5
    property single_grant_p;
        @(posedge clk) disable iff (!rst_n) !(grant_h && grant_g);
    endproperty
    single_grant_chk: assert property (single_grant_p);
endmodule

// File: rtl/sram_bank.sv
// One single-port memory bank with byte-lane writes and a registered read.
// Assumes the caller presents at most one access per cycle.
module sram_bank #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 1024,
    localparam int IDX_W = $clog2(WORDS),
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // Byte-lane write into the storage array.
    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int k = 0; k < BE_W; k++) begin
                if (be[k]) mem[idx][8*k +: 8] <= wdata[8*k +: 8];
            end
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata <= '0;
        else if (en && !we)  rdata <= mem[idx];
    end
endmodule

// File: rtl/wmon_regs.sv
// Configuration registers, per-bank write watchers, sticky status bits
// with write-zero-to-clear, enables and the combined interrupt.
// Assumes bank_wr already includes a nonzero byte enable.
module wmon_regs
    import sram_mon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic [NUM_BANKS-1:0] bank_wr,
    input  logic [IDX_W-1:0]     bank_idx [NUM_BANKS],
    output logic                 irq
);
    logic [IDX_W-1:0]     mon_idx [NUM_BANKS];
    logic [NUM_BANKS-1:0] mon_v;
    logic [NUM_BANKS-1:0] stat_q;
    logic [NUM_BANKS-1:0] en_q;
    logic [NUM_BANKS-1:0] hit;
    logic [NUM_BANKS-1:0] clr;

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_mon
            localparam logic [CFG_AW-1:0] MY_OFS = OFS_MON0 + CFG_AW'(4 * b);

            // Watcher register: valid flag and word index.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mon_v[b]   <= 1'b0;
                    mon_idx[b] <= '0;
                end else if (cfg_we && cfg_addr == MY_OFS) begin
                    mon_v[b]   <= cfg_wdata[0];
                    mon_idx[b] <= cfg_wdata[IDX_W+1:2];
                end
            end

            // Watch hit on the monitored word of this bank.
            assign hit[b] = mon_v[b] && bank_wr[b] && (bank_idx[b] == mon_idx[b]);

            // R7
            property hit_sets_p;
                @(posedge clk) disable iff (!rst_n)
                    (mon_v[b] && bank_wr[b] && bank_idx[b] == mon_idx[b]) |=> stat_q[b];
            endproperty
            hit_sets_chk: assert property (hit_sets_p);

            // R8
            property zero_clears_p;
                @(posedge clk) disable iff (!rst_n)
                    (cfg_we && cfg_addr == OFS_STAT && !cfg_wdata[b] && !hit[b]) |=> !stat_q[b];
            endproperty
            zero_clears_chk: assert property (zero_clears_p);

            // R9
            property enable_raises_p;
                @(posedge clk) disable iff (!rst_n)
                    (stat_q[b] && cfg_we && cfg_addr == OFS_EN && cfg_wdata[b]) |=> irq;
            endproperty
            enable_raises_chk: assert property (enable_raises_p);
        end
    endgenerate

    // Clear mask from a status write: a zero bit clears.
    assign clr = (cfg_we && cfg_addr == OFS_STAT) ? ~cfg_wdata[NUM_BANKS-1:0] : '0;

    // Sticky status; a watch hit wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | hit;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                               en_q <= '0;
        else if (cfg_we && cfg_addr == OFS_EN)    en_q <= cfg_wdata[NUM_BANKS-1:0];
    end

    // Combined interrupt output.
    assign irq = |(stat_q & en_q);

    // Combinational register readback.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            OFS_STAT: cfg_rdata[NUM_BANKS-1:0] = stat_q;
            OFS_EN:   cfg_rdata[NUM_BANKS-1:0] = en_q;
            default: begin
                for (int k = 0; k < NUM_BANKS; k++) begin
                    if (cfg_addr == OFS_MON0 + CFG_AW'(4 * k)) begin
                        cfg_rdata[0]         = mon_v[k];
                        cfg_rdata[IDX_W+1:2] = mon_idx[k];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/shared_sram_mon.sv
// Two-bank shared memory reached from a host and a guest port, with
// per-bank fixed-priority arbitration (host first) and per-bank write
// watchers feeding one host interrupt.
// Assumes: address top bit selects the bank; ready is combinational and
// read data follows one cycle after the granted cycle.
module shared_sram_mon
    import sram_mon_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int BANK_BYTES = 4096,
    localparam int BE_W      = DATA_W / 8,
    localparam int LANE_BITS = $clog2(BE_W),
    localparam int ADDR_W    = $clog2(BANK_BYTES) + 1,
    localparam int IDX_W     = ADDR_W - 1 - LANE_BITS,
    localparam int WORDS     = BANK_BYTES / BE_W,
    localparam int BANK_BIT  = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic [BE_W-1:0]   h_be,
    output logic              h_ready,
    output logic              h_rvalid,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              g_req,
    input  logic              g_we,
    input  logic [ADDR_W-1:0] g_addr,
    input  logic [DATA_W-1:0] g_wdata,
    input  logic [BE_W-1:0]   g_be,
    output logic              g_ready,
    output logic              g_rvalid,
    output logic [DATA_W-1:0] g_rdata,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              irq
);
    logic [NUM_BANKS-1:0] gnt_h, gnt_g;
    logic [NUM_BANKS-1:0] bank_wr;
    logic [IDX_W-1:0]     bank_idx   [NUM_BANKS];
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];
    logic                 h_sel_q, g_sel_q;

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic              h_hit, g_hit, b_en, b_we;
            logic [DATA_W-1:0] b_wdata;
            logic [BE_W-1:0]   b_be;

            assign h_hit = h_req && (h_addr[BANK_BIT] == 1'(b));
            assign g_hit = g_req && (g_addr[BANK_BIT] == 1'(b));

            sram_bank_arb u_arb (
                .clk(clk), .rst_n(rst_n),
                .h_hit(h_hit), .g_hit(g_hit),
                .grant_h(gnt_h[b]), .grant_g(gnt_g[b])
            );

            // Steer the winning port onto the bank.
            always_comb begin
                b_en        = gnt_h[b] || gnt_g[b];
                b_we        = gnt_h[b] ? h_we    : g_we;
                b_wdata     = gnt_h[b] ? h_wdata : g_wdata;
                b_be        = gnt_h[b] ? h_be    : g_be;
                bank_idx[b] = gnt_h[b] ? h_addr[BANK_BIT-1:LANE_BITS]
                                       : g_addr[BANK_BIT-1:LANE_BITS];
                bank_wr[b]  = b_en && b_we && (|b_be);
            end

            sram_bank #(.DATA_W(DATA_W), .WORDS(WORDS)) u_mem (
                .clk(clk), .rst_n(rst_n),
                .en(b_en), .we(b_we), .idx(bank_idx[b]),
                .wdata(b_wdata), .be(b_be), .rdata(bank_rdata[b])
            );
        end
    endgenerate

    assign h_ready = |gnt_h;
    assign g_ready = |gnt_g;

    // Read-valid and bank-of-origin tracking for each port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rvalid <= 1'b0;
            g_rvalid <= 1'b0;
            h_sel_q  <= 1'b0;
            g_sel_q  <= 1'b0;
        end else begin
            h_rvalid <= h_ready && !h_we;
            g_rvalid <= g_ready && !g_we;
            if (h_ready) h_sel_q <= h_addr[BANK_BIT];
            if (g_ready) g_sel_q <= g_addr[BANK_BIT];
        end
    end

    assign h_rdata = bank_rdata[h_sel_q];
    assign g_rdata = bank_rdata[g_sel_q];

    wmon_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .bank_wr(bank_wr), .bank_idx(bank_idx), .irq(irq)
    );

    // R5
    property same_bank_stall_p;
        @(posedge clk) disable iff (!rst_n)
            (h_req && g_req && h_addr[BANK_BIT] == g_addr[BANK_BIT]) |-> (h_ready && !g_ready);
    endproperty
    same_bank_stall_chk: assert property (same_bank_stall_p);

    // R4
    property split_bank_parallel_p;
        @(posedge clk) disable iff (!rst_n)
            (h_req && g_req && h_addr[BANK_BIT] != g_addr[BANK_BIT]) |-> (h_ready && g_ready);
    endproperty
    split_bank_parallel_chk: assert property (split_bank_parallel_p);

    // R2
    property host_read_latency_p;
        @(posedge clk) disable iff (!rst_n) (h_ready && !h_we) |=> h_rvalid;
    endproperty
    host_read_latency_chk: assert property (host_read_latency_p);

    // R2
    property guest_read_latency_p;
        @(posedge clk) disable iff (!rst_n) (g_ready && !g_we) |=> g_rvalid;
    endproperty
    guest_read_latency_chk: assert property (guest_read_latency_p);
endmodule

// File: tb/tb_shared_sram_mon.sv
module tb_shared_sram_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 0, h_we = 0, g_req = 0, g_we = 0;
    logic [12:0] h_addr = '0, g_addr = '0;
    logic [31:0] h_wdata = '0, g_wdata = '0;
    logic [3:0]  h_be = '0, g_be = '0;
    logic        h_ready, h_rvalid, g_ready, g_rvalid, irq;
    logic [31:0] h_rdata, g_rdata, cfg_rdata;
    logic        cfg_we = 0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    always #2 clk = ~clk;

    shared_sram_mon dut (
        .clk(clk), .rst_n(rst_n),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be),
        .h_ready(h_ready), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
        .g_req(g_req), .g_we(g_we), .g_addr(g_addr), .g_wdata(g_wdata), .g_be(g_be),
        .g_ready(g_ready), .g_rvalid(g_rvalid), .g_rdata(g_rdata),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        port;   // 0 host, 1 guest
        logic        we;
        logic [12:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 13'h0004, 32'hDEAD_BEEF, 4'hF, 32'h0},
        '{1'b1, 1'b1, 13'h1004, 32'hCAFE_0123, 4'hF, 32'h0},
        '{1'b0, 1'b0, 13'h1004, 32'h0,         4'hF, 32'hCAFE_0123},
        '{1'b1, 1'b0, 13'h0004, 32'h0,         4'hF, 32'hDEAD_BEEF},
        '{1'b1, 1'b1, 13'h0004, 32'h1122_3344, 4'h5, 32'h0},
        '{1'b0, 1'b0, 13'h0004, 32'h0,         4'hF, 32'hDE22_BE44},
        '{1'b0, 1'b1, 13'h1FFC, 32'h0BAD_F00D, 4'hF, 32'h0},
        '{1'b1, 1'b0, 13'h1FFC, 32'h0,         4'hF, 32'h0BAD_F00D}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic port_op(input logic p, input logic we, input logic [12:0] a,
                           input logic [31:0] d, input logic [3:0] be,
                           output logic rdy, output logic rv, output logic [31:0] rd);
        @(negedge clk);
        if (!p) begin h_req = 1; h_we = we; h_addr = a; h_wdata = d; h_be = be; end
        else    begin g_req = 1; g_we = we; g_addr = a; g_wdata = d; g_be = be; end
        #1 rdy = p ? g_ready : h_ready;
        @(negedge clk);
        h_req = 0; g_req = 0;
        rv = p ? g_rvalid : h_rvalid;
        rd = p ? g_rdata : h_rdata;
    endtask

    task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic cfg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic        rdy, rv;
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        #1 check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rvalid", {30'b0, h_rvalid, g_rvalid}, 32'h0);
        cfg_rd(4'h0, rd); check("R1 mon0", rd, 32'h0);
        cfg_rd(4'h4, rd); check("R1 mon1", rd, 32'h0);
        cfg_rd(4'h8, rd); check("R1 stat", rd, 32'h0);
        cfg_rd(4'hC, rd); check("R1 en", rd, 32'h0);

        // R2 / R3 table walk (entry 5 checks the lane-masked write of entry 4)
        for (int i = 0; i < NVEC; i++) begin
            port_op(VEC[i].port, VEC[i].we, VEC[i].addr, VEC[i].data, VEC[i].be, rdy, rv, rd);
            check("R2 ready", {31'b0, rdy}, 32'h1);
            if (VEC[i].we) check("R2 no rvalid on write", {31'b0, rv}, 32'h0);
            else begin
                check("R2 rvalid", {31'b0, rv}, 32'h1);
                check("R3 R2 rdata", rd, VEC[i].exp);
            end
        end

        // R4 parallel access to different banks
        @(negedge clk);
        h_req = 1; h_we = 1; h_addr = 13'h0010; h_wdata = 32'hAAAA_0001; h_be = 4'hF;
        g_req = 1; g_we = 1; g_addr = 13'h1010; g_wdata = 32'hBBBB_0002; g_be = 4'hF;
        #1 check("R4 both ready", {30'b0, h_ready, g_ready}, 32'h3);
        @(negedge clk); h_req = 0; g_req = 0;
        port_op(1'b1, 1'b0, 13'h0010, 0, 4'hF, rdy, rv, rd); check("R4 bank0 data", rd, 32'hAAAA_0001);
        port_op(1'b0, 1'b0, 13'h1010, 0, 4'hF, rdy, rv, rd); check("R4 bank1 data", rd, 32'hBBBB_0002);

        // R5 same-bank conflict, host held for two cycles
        @(negedge clk);
        h_req = 1; h_we = 1; h_addr = 13'h0040; h_wdata = 32'h1111_1111; h_be = 4'hF;
        g_req = 1; g_we = 1; g_addr = 13'h0044; g_wdata = 32'h2222_2222; g_be = 4'hF;
        #1 check("R5 stall cycle 1", {30'b0, h_ready, g_ready}, 32'h2);
        @(negedge clk);
        h_addr = 13'h0048; h_wdata = 32'h3333_3333;
        #1 check("R5 stall cycle 2", {30'b0, h_ready, g_ready}, 32'h2);
        @(negedge clk);
        h_req = 0;
        #1 check("R5 guest granted", {31'b0, g_ready}, 32'h1);
        @(negedge clk); g_req = 0;
        port_op(1'b0, 1'b0, 13'h0044, 0, 4'hF, rdy, rv, rd); check("R5 guest write landed", rd, 32'h2222_2222);
        port_op(1'b0, 1'b0, 13'h0048, 0, 4'hF, rdy, rv, rd); check("R5 host write landed", rd, 32'h3333_3333);

        // R6 watcher register layout
        cfg_wr(4'h4, 32'hFFFF_FFFF);
        cfg_rd(4'h4, rd); check("R6 mon1 mask", rd, 32'h0000_0FFD);
        cfg_wr(4'h0, 32'h0000_0021);
        cfg_rd(4'h0, rd); check("R6 mon0", rd, 32'h0000_0021);
        cfg_wr(4'h4, 32'h0000_0020);
        cfg_rd(4'h4, rd); check("R6 mon1 invalid", rd, 32'h0000_0020);

        // R7 non-triggering accesses
        port_op(1'b1, 1'b0, 13'h0020, 0, 4'hF, rdy, rv, rd);
        port_op(1'b0, 1'b1, 13'h0024, 32'h5, 4'hF, rdy, rv, rd);
        port_op(1'b0, 1'b1, 13'h0020, 32'h5, 4'h0, rdy, rv, rd);
        port_op(1'b0, 1'b1, 13'h1020, 32'h5, 4'hF, rdy, rv, rd);
        cfg_rd(4'h8, rd); check("R7 no trigger", rd, 32'h0);
        // R7 guest partial-lane write to watched word
        port_op(1'b1, 1'b1, 13'h0020, 32'h0000_7700, 4'h2, rdy, rv, rd);
        cfg_rd(4'h8, rd); check("R7 bank0 set", rd, 32'h1);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        cfg_wr(4'h4, 32'h0000_0021);
        port_op(1'b0, 1'b1, 13'h1020, 32'h9, 4'hF, rdy, rv, rd);
        cfg_rd(4'h8, rd); check("R7 bank1 set", rd, 32'h3);

        // R8 write-one no effect, write-zero clears
        cfg_wr(4'h8, 32'h3);
        cfg_rd(4'h8, rd); check("R8 ones keep", rd, 32'h3);
        cfg_wr(4'h8, 32'h2);
        cfg_rd(4'h8, rd); check("R8 clear bit0", rd, 32'h2);
        // R8 simultaneous hit and clear on bank 1
        @(negedge clk);
        cfg_we = 1; cfg_addr = 4'h8; cfg_wdata = 32'h0;
        h_req = 1; h_we = 1; h_addr = 13'h1020; h_wdata = 32'h1; h_be = 4'h1;
        @(negedge clk); cfg_we = 0; h_req = 0;
        cfg_rd(4'h8, rd); check("R8 set wins", rd, 32'h2);
        cfg_wr(4'h8, 32'h0);
        cfg_rd(4'h8, rd); check("R8 cleared", rd, 32'h0);

        // R9 enabling an already-set status
        port_op(1'b1, 1'b1, 13'h0020, 32'h1, 4'h1, rdy, rv, rd);
        check("R9 irq before enable", {31'b0, irq}, 32'h0);
        cfg_wr(4'hC, 32'h1);
        check("R9 irq after enable", {31'b0, irq}, 32'h1);
        cfg_wr(4'hC, 32'h2);
        check("R9 other enable only", {31'b0, irq}, 32'h0);
        cfg_rd(4'hC, rd); check("R10 en readback", rd, 32'h2);
        port_op(1'b0, 1'b1, 13'h1020, 32'h1, 4'h1, rdy, rv, rd);
        check("R9 irq bank1", {31'b0, irq}, 32'h1);
        cfg_wr(4'h8, 32'h0);
        check("R9 irq after clear", {31'b0, irq}, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule